// File: doc/BRIEF.md
# Raw sample to physical float scaler

This block turns a stream of raw signed integer converter samples into single-precision floating-point values in physical units. Each accepted sample is first turned into an exact IEEE-754 single-precision number. It is then multiplied by a 32-bit single-precision gain and sent out on a stream master port. The raw code relates to the analog input as code = voltage x 2^15 / full scale, where full scale is normally 10 V and 5 V on some boards. The gain is therefore full scale / 2^15 divided by the sensor sensitivity. A 10 V range with a 5 mV/V sensor gives about 0.06104 V per code, encoded as 0x3D7A0514. That value is provided as `SCALE_GAIN_DEFAULT` in the package.

The gain is a static word that the block treats as an operand that is always valid. It is captured alongside each sample, so no handshake is needed on it. The path never stalls. The slave ready is held high, and a result appears exactly four cycles after its sample, at a 250 MHz target clock. The multiply rounds to nearest-even. A result too large to represent saturates to a signed infinity.

Top module: `adc_gain_scaler`

## Requirements
- R1: While reset is asserted and until the first sample has crossed the pipeline, m_tvalid is 0 and m_tdata is 0x00000000.
- R2: s_tready is 1 in every cycle after reset; the block never applies backpressure.
- R3: m_tvalid in a cycle equals the value s_tvalid had four clock cycles earlier. Each result is produced exactly four cycles after its sample was accepted.
- R4: With gain 0x3F800000 (1.0), the output is the exact single-precision encoding of the two's-complement sample. 0 gives 0x00000000, 1 gives 0x3F800000 and -32768 gives 0xC7000000.
- R5: For normal gains, bits 30:0 of the output are the exact product sample x gain rounded once to nearest, with ties going to the even significand.
- R6: Output bit 31 is the exclusive-or of sample bit 15 and gain bit 31. This also holds for zero and infinite results, so a sample of 0 with a negative gain gives 0x80000000.
- R7: When the rounded result exponent reaches 255 or more, the output is infinity: exponent field 0xFF, mantissa field 0, carrying the R6 sign. For example, gain 0x7F000000 with sample 2 gives 0x7F800000.
- R8: Each sample uses the gain_word present in the cycle in which that sample is accepted. A gain change affects only samples accepted in that cycle or later.
- R9: While m_tvalid is 0, m_tdata keeps the last result. Inputs presented with s_tvalid at 0 have no effect on the output.
- R10: A gain whose exponent field (bits 30:23) is 0 is treated as zero. The result is a zero carrying the R6 sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_tvalid | input | 1 | Sample valid |
| s_tready | output | 1 | Sample ready, held at 1 |
| s_tdata | input | IN_W (16) | Raw signed sample |
| gain_word | input | 32 | Single-precision gain, always treated as valid |
| m_tvalid | output | 1 | Result valid |
| m_tdata | output | 32 | Scaled single-precision result |

## Verification
A gain change and a sample acceptance can land in the same cycle. The block must then pair that sample with the new gain, while samples still in flight keep the old one. The bench changes gain_word on every cycle of a back-to-back burst. A behavioural model computes each expected word from the gain seen at the same clock edge as its sample, and compares every output cycle against it. A second coincidence is a rounding carry that meets the overflow limit. Gains near the largest finite value are used to check that the post-round exponent decides between the largest finite number and infinity.

// File: rtl/scale_pkg.sv
package scale_pkg;
   localparam int FP_EXP_W  = 8;
   localparam int FP_MAN_W  = 23;
   localparam int FP_BIAS   = 127;
   localparam int SIG_W     = FP_MAN_W + 1;
   localparam int PROD_W    = 2 * SIG_W;
   localparam int EXPS_W    = FP_EXP_W + 2;
   localparam int LATENCY   = 4;
   localparam logic [31:0] SCALE_GAIN_DEFAULT = 32'h3D7A0514;

   typedef struct packed {
      logic                sgn;
      logic [FP_EXP_W-1:0] exp;
      logic [FP_MAN_W-1:0] man;
   } fp32_t;
endpackage

// File: rtl/adc_i2f.sv
module adc_i2f
   import scale_pkg::*;
#(
   parameter int IN_W = 16
) (
   input  logic [IN_W-1:0] raw,
   output fp32_t           f
);
   localparam int LW = $clog2(IN_W);

   generate
      if (IN_W < 2 || IN_W > SIG_W) begin : g_bad_width
         $error("adc_i2f: IN_W must lie in 2..SIG_W for an exact conversion");
      end
   endgenerate

   logic [IN_W-1:0]  mag;
   logic [LW-1:0]    lead;
   logic [SIG_W-1:0] norm;

   assign mag = raw[IN_W-1] ? (~raw + 1'b1) : raw;

   // priority encoder: highest set bit of the magnitude
   always_comb begin
      lead = '0;
      for (int i = 0; i < IN_W; i++) begin
         if (mag[i]) lead = LW'(i);
      end
   end

   assign norm = {{(SIG_W-IN_W){1'b0}}, mag} << (FP_MAN_W - int'(lead));

   always_comb begin
      f.sgn = raw[IN_W-1];
      f.exp = (mag == '0) ? '0 : FP_EXP_W'(FP_BIAS + int'(lead));
      f.man = norm[FP_MAN_W-1:0];
   end
endmodule

// File: rtl/fp_round_pack.sv
module fp_round_pack
   import scale_pkg::*;
(
   input  logic                     sgn,
   input  logic                     zero,
   input  logic [PROD_W-1:0]        prod,
   input  logic signed [EXPS_W-1:0] esum,
   output fp32_t                    y
);
   logic             hi, guard, sticky, up, carry;
   logic [SIG_W-1:0] keep;
   logic [SIG_W:0]   rnd;
   logic signed [EXPS_W-1:0] e_f;

   always_comb begin
      hi     = prod[PROD_W-1];
      keep   = hi ? prod[PROD_W-1 -: SIG_W] : prod[PROD_W-2 -: SIG_W];
      guard  = hi ? prod[SIG_W-1] : prod[SIG_W-2];
      sticky = hi ? |prod[SIG_W-2:0] : |prod[SIG_W-3:0];
      up     = guard & (sticky | keep[0]);
      rnd    = {1'b0, keep} + (SIG_W+1)'(up);
      carry  = rnd[SIG_W];
      e_f    = esum + $signed({{(EXPS_W-1){1'b0}}, hi}) + $signed({{(EXPS_W-1){1'b0}}, carry});
      y.sgn  = sgn;
      if (zero) begin
         y.exp = '0;
         y.man = '0;
      end else if (e_f >= $signed(EXPS_W'(2**FP_EXP_W - 1))) begin
         y.exp = '1;
         y.man = '0;
      end else if (e_f <= $signed(EXPS_W'(0))) begin
         y.exp = '0;
         y.man = '0;
      end else begin
         y.exp = e_f[FP_EXP_W-1:0];
         y.man = carry ? rnd[SIG_W-1:1] : rnd[FP_MAN_W-1:0];
      end
   end
endmodule

// File: rtl/fp_mul_pipe.sv
module fp_mul_pipe
   import scale_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  in_valid,
   input  fp32_t op_a,
   input  fp32_t op_b,
   output logic  out_valid,
   output fp32_t result
);
   logic                     v3, sgn3, zero3;
   logic [PROD_W-1:0]        prod3;
   logic signed [EXPS_W-1:0] esum3;
   fp32_t                    packed_res;

   logic [PROD_W-1:0]        prod_c;
   logic signed [EXPS_W-1:0] esum_c;

   assign prod_c = {1'b1, op_a.man} * {1'b1, op_b.man};
   assign esum_c = $signed({2'b00, op_a.exp}) + $signed({2'b00, op_b.exp})
                 - $signed(EXPS_W'(FP_BIAS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v3    <= 1'b0;
         sgn3  <= 1'b0;
         zero3 <= 1'b1;
         prod3 <= '0;
         esum3 <= '0;
      end else begin
         v3 <= in_valid;
         if (in_valid) begin
            sgn3  <= op_a.sgn ^ op_b.sgn;
            zero3 <= (op_a.exp == '0) || (op_b.exp == '0);
            prod3 <= prod_c;
            esum3 <= esum_c;
         end
      end
   end

   fp_round_pack u_rnd (
      .sgn  (sgn3),
      .zero (zero3),
      .prod (prod3),
      .esum (esum3),
      .y    (packed_res)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
      end else begin
         out_valid <= v3;
         if (v3) result <= packed_res;
      end
   end
endmodule

// File: rtl/adc_gain_scaler.sv
module adc_gain_scaler
   import scale_pkg::*;
#(
   parameter int IN_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            s_tvalid,
   output logic            s_tready,
   input  logic [IN_W-1:0] s_tdata,
   input  logic [31:0]     gain_word,
   output logic            m_tvalid,
   output logic [31:0]     m_tdata
);
   generate
      if ($bits(fp32_t) != 32) begin : g_bad_fmt
         $error("adc_gain_scaler: float word must be 32 bits");
      end
   endgenerate

   assign s_tready = 1'b1;

   logic            v1, v2;
   logic [IN_W-1:0] x1;
   logic [31:0]     g1;
   fp32_t           a_conv, a2, b2, res;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v1 <= 1'b0;
         x1 <= '0;
         g1 <= '0;
      end else begin
         v1 <= s_tvalid;
         if (s_tvalid) begin
            x1 <= s_tdata;
            g1 <= gain_word;
         end
      end
   end

   adc_i2f #(.IN_W(IN_W)) u_conv (
      .raw (x1),
      .f   (a_conv)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v2 <= 1'b0;
         a2 <= '0;
         b2 <= '0;
      end else begin
         v2 <= v1;
         if (v1) begin
            a2 <= a_conv;
            b2 <= fp32_t'(g1);
         end
      end
   end

   fp_mul_pipe u_mul (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (v2),
      .op_a      (a2),
      .op_b      (b2),
      .out_valid (m_tvalid),
      .result    (res)
   );

   assign m_tdata = res;
endmodule

// File: rtl/adc_gain_scaler_chk.sv
module adc_gain_scaler_chk #(
   parameter int IN_W = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            s_tvalid,
   input logic            s_tready,
   input logic [IN_W-1:0] s_tdata,
   input logic [31:0]     gain_word,
   input logic            m_tvalid,
   input logic [31:0]     m_tdata
);
   logic [2:0] since_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) since_rst <= '0;
      else if (since_rst < 3'd4) since_rst <= since_rst + 3'd1;
   end

   AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (!m_tvalid && m_tdata == 32'h0)); // R1

   AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n) s_tready); // R2

   AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 3'd4) |-> (m_tvalid == $past(s_tvalid, 4))); // R3

   AST_SIGN_XOR: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 3'd4 && m_tvalid) |->
      (m_tdata[31] == ($past(s_tdata[IN_W-1], 4) ^ $past(gain_word[31], 4)))); // R6

   AST_INF_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      (m_tvalid && m_tdata[30:23] == 8'hFF) |-> (m_tdata[22:0] == 23'h0)); // R7

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 3'd1 && !m_tvalid) |-> $stable(m_tdata)); // R9
endmodule

bind adc_gain_scaler adc_gain_scaler_chk #(.IN_W(IN_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .s_tvalid  (s_tvalid),
   .s_tready  (s_tready),
   .s_tdata   (s_tdata),
   .gain_word (gain_word),
   .m_tvalid  (m_tvalid),
   .m_tdata   (m_tdata)
);

// File: tb/sim_adc_gain_scaler.sv
`timescale 1ns/1ps
module sim_adc_gain_scaler;
   import scale_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        s_tvalid = 1'b0;
   logic        s_tready;
   logic [15:0] s_tdata = '0;
   logic [31:0] gain_word = 32'h3F800000;
   logic        m_tvalid;
   logic [31:0] m_tdata;

   int compared = 0;
   int mismatched = 0;
   int cyc = 0;
   bit started = 0;
   string cur_tag = "R9";

   bit         qv[$];
   bit [31:0]  qd[$];
   string      qt[$];
   bit [31:0]  hold = '0;

   always #2.5 clk = ~clk;

   adc_gain_scaler u0 (
      .clk(clk), .rst_n(rst_n), .s_tvalid(s_tvalid), .s_tready(s_tready),
      .s_tdata(s_tdata), .gain_word(gain_word), .m_tvalid(m_tvalid), .m_tdata(m_tdata)
   );

   function automatic bit [31:0] fmodel(input bit [15:0] x, input bit [31:0] g);
      bit        sg;
      int        eg, p, e, s;
      bit [63:0] mag, mg, pr, m, rem, half;
      sg = x[15] ^ g[31];
      eg = int'(g[30:23]);
      if (x == 16'h0 || eg == 0) return {sg, 31'h0};
      mag = x[15] ? (64'd65536 - 64'(x)) : 64'(x);
      mg  = 64'h800000 | 64'(g[22:0]);
      pr  = mag * mg;
      p = 0;
      for (int i = 0; i < 48; i++) if (pr[i]) p = i;
      e = p + eg - 23;
      if (p <= 23) m = pr << (23 - p);
      else begin
         s = p - 23;
         m = pr >> s;
         rem = pr & ((64'd1 << s) - 64'd1);
         half = 64'd1 << (s - 1);
         if (rem > half || (rem == half && m[0])) m = m + 64'd1;
         if (m == (64'd1 << 24)) begin m = m >> 1; e = e + 1; end
      end
      if (e >= 255) return {sg, 8'hFF, 23'h0};
      if (e <= 0) return {sg, 31'h0};
      return {sg, e[7:0], m[22:0]};
   endfunction

   task automatic report(input string req, input bit [31:0] act, input bit [31:0] exp_v);
      compared++;
      if (act !== exp_v) begin
         mismatched++;
         $display("FAIL %s actual=%08h expected=%08h (cycle %0d)", req, act, exp_v, cyc);
      end
   endtask

   task automatic put(input bit v, input bit [15:0] x, input bit [31:0] g, input string t);
      @(negedge clk);
      s_tvalid  = v;
      s_tdata   = x;
      gain_word = g;
      cur_tag   = t;
   endtask

   // reference pipeline: one entry per clock edge
   always @(posedge clk) begin
      cyc++;
      if (rst_n) begin
         if (s_tvalid) hold = fmodel(s_tdata, gain_word);
         qv.push_back(s_tvalid);
         qd.push_back(hold);
         qt.push_back(s_tvalid ? cur_tag : "R9");
         if (qv.size() > 8) begin
            void'(qv.pop_front()); void'(qd.pop_front()); void'(qt.pop_front());
         end
      end
      if (cyc > 20000) begin
         mismatched++;
         $display("FAIL R3 watchdog: actual=running expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   always @(negedge clk) begin
      bit        ev;
      bit [31:0] ed;
      string     et;
      if (rst_n && started) begin
         if (qv.size() >= 4) begin
            ev = qv[qv.size()-4]; ed = qd[qv.size()-4]; et = qt[qv.size()-4];
         end else begin
            ev = 1'b0; ed = 32'h0; et = "R1";
         end
         report("R3", 32'(m_tvalid), 32'(ev));
         report(et, m_tdata, ed);
         report("R2", 32'(s_tready), 32'h1);
      end
   end

   initial begin
      bit [15:0] conv_set [12];
      bit [31:0] gset [4];
      conv_set = '{16'h0000, 16'h0001, 16'hFFFF, 16'h0002, 16'h0003, 16'h0007,
                   16'h00FF, 16'hFF00, 16'h7FFF, 16'h8000, 16'h3039, 16'hEFFF};
      gset = '{32'h3F800000, SCALE_GAIN_DEFAULT, 32'hC1200000, 32'h3E000001};

      // R1: reset state
      repeat (3) begin
         @(negedge clk);
         report("R1", {31'h0, m_tvalid}, 32'h0);
         report("R1", m_tdata, 32'h0);
      end
      // R4: model anchors against known encodings
      report("R4", fmodel(16'h8000, 32'h3F800000), 32'hC7000000);
      report("R4", fmodel(16'h0000, 32'h3F800000), 32'h00000000);
      report("R6", fmodel(16'h0000, 32'hBD7A0514), 32'h80000000);
      report("R7", fmodel(16'h0002, 32'h7F000000), 32'h7F800000);
      @(negedge clk);
      rst_n = 1'b1;
      started = 1;

      // R4: exact conversion with unit gain
      foreach (conv_set[i]) put(1'b1, conv_set[i], 32'h3F800000, "R4");
      put(1'b0, 16'h1234, 32'h3F800000, "R9");

      // R5: default gain, gappy valid pattern
      for (int k = 0; k < 200; k++)
         put(($urandom % 4) != 0, 16'($urandom), SCALE_GAIN_DEFAULT, "R5");
      // R5: ties to even
      put(1'b1, 16'd3, 32'h3F800001, "R5");
      put(1'b1, 16'd5, 32'h3F800001, "R5");
      put(1'b1, 16'd7, 32'h3F800003, "R5");
      put(1'b1, 16'hFFFD, 32'h3F800001, "R5");
      // R5: random normal gains
      for (int k = 0; k < 200; k++)
         put(1'b1, 16'($urandom), {1'b0, 8'(90 + $urandom % 70), 23'($urandom)}, "R5");

      // R6: negative gain, mixed signs and zero sample
      put(1'b1, 16'h0000, 32'hBD7A0514, "R6");
      for (int k = 0; k < 30; k++)
         put(1'b1, 16'($urandom), 32'hBD7A0514, "R6");

      // R7: overflow to infinity and near-limit finite results
      put(1'b1, 16'd1,    32'h7F000000, "R7");
      put(1'b1, 16'd2,    32'h7F000000, "R7");
      put(1'b1, 16'hFFFD, 32'h7F000000, "R7");
      put(1'b1, 16'd1,    32'h7F7FFFFF, "R7");
      put(1'b1, 16'hFFFF, 32'h7F7FFFFF, "R7");
      put(1'b1, 16'h7FFF, 32'hFF7FFFFF, "R7");

      // R8: gain changes every cycle in a back-to-back burst
      for (int k = 0; k < 40; k++)
         put(1'b1, 16'($urandom), gset[k % 4], "R8");

      // R9: inputs without valid must not disturb the held output
      for (int k = 0; k < 10; k++)
         put(1'b0, 16'($urandom), 32'($urandom), "R9");

      // R10: gain with zero exponent field
      put(1'b1, 16'd5,    32'h00400000, "R10");
      put(1'b1, 16'hFFF9, 32'h80000001, "R10");
      put(1'b1, 16'hFFF9, 32'h00000001, "R10");

      for (int k = 0; k < 8; k++) put(1'b0, 16'h0, SCALE_GAIN_DEFAULT, "R9");
      @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule